// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the processor-facing side of a three-channel interval timer. An 8-bit bus made up of an active-low chip select, active-low read and write strobes, a 2-bit address and separate input and output data buses reaches three count channels and one shared control register. The block sends each channel its programmed mode, its BCD flag and every complete reload value. From each channel it takes the live 16-bit count, the OUT level and the null-count flag.

Every channel keeps its own byte-access setting: low byte only, high byte only, or low byte followed by high byte. The block steps through the bytes of a two-byte write or read for each channel. It can freeze a channel's count for a consistent read, either with a counter-latch command or with a read-back command. A read-back command can also capture a status byte. When status and count are both captured, the status byte comes out on the first read of that channel and the frozen count on the reads after it. The channel keeps counting the whole time.

Top module: `tmr_bus_if`

## Requirements
- R1: An access takes place only while `cs_ni` is low and exactly one of `rd_ni`/`wr_ni` is low, and only once for each assertion of a strobe, even if the strobe is held low for several cycles. Address 0, 1 and 2 select channels 0, 1 and 2. Address 3 selects the control register.
- R2: After reset, every channel reports OUT low, null count clear, two-byte access, mode 0 and binary (status 0x30). `data_o` is 0x00 and no latch is pending.
- R3: A data write in low-only access (field 01) loads {0x00,d}. In high-only access (field 10) it loads {d,0x00}. In two-byte access (field 11) the first write is held and the second write loads {second,first}. `load_o[c]` pulses for one cycle, with `load_val_o`, in the cycle after the completing write.
- R4: A control write with bits 7:6 = c and bits 5:4 ≠ 00 sets channel c's access field, mode (bits 3:1) and BCD (bit 0). It pulses `ctrl_wr_o[c]`, restarts the channel's byte sequencing and discards any pending latch of that channel.
- R5: An unlatched read returns the live count's low byte (field 01) or high byte (field 10). In field 11, reads alternate low byte then high byte.
- R6: A control write with bits 5:4 = 00 latches channel c's count. Reads then return the frozen value, in the order of the access field, until it has been fully read. After that, reads return the live count again.
- R7: A count latch request made while a latched count has not yet been fully read is ignored.
- R8: A control write with bits 7:6 = 11 is a read-back command. Bit 5 low latches counts, bit 4 low latches status, and bits 1, 2 and 3 select channels 0, 1 and 2.
- R9: The status byte is {OUT, null count, access field[1:0], mode[2:0], BCD}, from bit 7 down to bit 0, captured when the read-back command is written.
- R10: When status and count are both latched, the first read returns the status byte and the following reads return the latched count. A change of the live count in between has no effect on them.
- R11: A status latch request made while an earlier status byte is still unread is ignored.
- R12: A read of address 3 returns 0x00. An access with both strobes low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, registered, valid one cycle after the read strobe falls |
| cnt_i | input | NCH*16 | Live count of each channel |
| out_i | input | NCH | OUT level of each channel |
| null_i | input | NCH | Null-count flag of each channel |
| mode_o | output | NCH*3 | Programmed mode of each channel |
| bcd_o | output | NCH | BCD flag of each channel |
| ctrl_wr_o | output | NCH | One-cycle pulse when a channel's control word is written |
| load_o | output | NCH | One-cycle pulse when a full reload value is written |
| load_val_o | output | NCH*16 | Reload value of each channel |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a read-back request and an earlier count latch both target one channel. The bench issues a latch and then a second latch or read-back before reading, and checks that the first frozen value comes out intact. In the second, the live count keeps moving during a status-then-count readout. The bench changes `cnt_i` and `out_i` between the command and each read, and compares every byte with the value captured at command time. A control write that lands on a channel while a latch is pending is also provoked, and the bench checks that the next read returns live data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    RW_LATCH = 2'b00,
    RW_LO    = 2'b01,
    RW_HI    = 2'b10,
    RW_WORD  = 2'b11
  } rw_e;

  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] SEL_RB    = 2'b11;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/tmr_bus_strobe.sv
module tmr_bus_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic rd_ev_o,
  output logic wr_ev_o
);
  logic rd_act, wr_act, rd_q, wr_q;

  // exactly one strobe low under chip select
  assign rd_act = !cs_ni && !rd_ni && wr_ni;
  assign wr_act = !cs_ni && !wr_ni && rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign rd_ev_o = rd_act && !rd_q;
  assign wr_ev_o = wr_act && !wr_q;
endmodule

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode import tmr_pkg::*; #(
  parameter int unsigned NCH = 3
) (
  input  logic             rd_ev_i,
  input  logic             wr_ev_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       data_i,
  output logic [NCH-1:0]   ch_rd_o,
  output logic [NCH-1:0]   ch_wr_o,
  output logic [NCH-1:0]   cw_o,
  output logic [NCH-1:0]   lat_o,
  output logic [NCH-1:0]   rb_cnt_o,
  output logic [NCH-1:0]   rb_st_o
);
  logic is_ctrl, is_rb;
  assign is_ctrl = wr_ev_i && (addr_i == CTRL_ADDR);
  assign is_rb   = is_ctrl && (data_i[7:6] == SEL_RB);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit         = is_ctrl && (data_i[7:6] == 2'(c));
    assign cw_o[c]     = hit && (data_i[5:4] != RW_LATCH);
    assign lat_o[c]    = hit && (data_i[5:4] == RW_LATCH);
    assign rb_cnt_o[c] = is_rb && !data_i[5] && data_i[c+1];
    assign rb_st_o[c]  = is_rb && !data_i[4] && data_i[c+1];
    assign ch_wr_o[c]  = wr_ev_i && (addr_i == 2'(c));
    assign ch_rd_o[c]  = rd_ev_i && (addr_i == 2'(c));
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port import tmr_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              cw_i,
  input  logic              lat_i,
  input  logic              rb_cnt_i,
  input  logic              rb_st_i,
  input  logic [7:0]        data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              out_i,
  input  logic              null_i,
  output logic [7:0]        rd_byte_o,
  output logic [2:0]        mode_o,
  output logic              bcd_o,
  output logic              ctrl_wr_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              st_vld_o,
  output logic              cl_vld_o,
  output logic [CNT_W-1:0]  cl_val_o
);
  rw_e              rw_q;
  logic [2:0]       mode_q;
  logic             bcd_q, wr_hi_q, rd_hi_q, st_vld_q, cl_vld_q;
  logic [7:0]       lo_q, st_q;
  logic [CNT_W-1:0] cl_q;
  logic [7:0]       status;
  logic [CNT_W-1:0] src;
  logic             sel_hi;

  assign status = {out_i, null_i, rw_q, mode_q, bcd_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q       <= RW_WORD;
      mode_q     <= 3'd0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      st_vld_q   <= 1'b0;
      cl_vld_q   <= 1'b0;
      lo_q       <= '0;
      st_q       <= '0;
      cl_q       <= '0;
      ctrl_wr_o  <= 1'b0;
      load_o     <= 1'b0;
      load_val_o <= '0;
    end else begin
      ctrl_wr_o <= cw_i;
      load_o    <= 1'b0;
      if (cw_i) begin
        rw_q     <= rw_e'(data_i[5:4]);
        mode_q   <= data_i[3:1];
        bcd_q    <= data_i[0];
        wr_hi_q  <= 1'b0;
        rd_hi_q  <= 1'b0;
        st_vld_q <= 1'b0;
        cl_vld_q <= 1'b0;
      end else begin
        if ((lat_i || rb_cnt_i) && !cl_vld_q) begin
          cl_vld_q <= 1'b1;
          cl_q     <= cnt_i;
        end
        if (rb_st_i && !st_vld_q) begin
          st_vld_q <= 1'b1;
          st_q     <= status;
        end
        if (wr_i) begin
          unique case (rw_q)
            RW_LO: begin
              load_o     <= 1'b1;
              load_val_o <= {8'h00, data_i};
            end
            RW_HI: begin
              load_o     <= 1'b1;
              load_val_o <= {data_i, 8'h00};
            end
            default: begin
              if (wr_hi_q) begin
                load_o     <= 1'b1;
                load_val_o <= {data_i, lo_q};
                wr_hi_q    <= 1'b0;
              end else begin
                lo_q    <= data_i;
                wr_hi_q <= 1'b1;
              end
            end
          endcase
        end
        if (rd_i) begin
          if (st_vld_q) begin
            st_vld_q <= 1'b0;
          end else begin
            if (rw_q == RW_WORD) rd_hi_q <= !rd_hi_q;
            // latch released once its last byte leaves
            if (cl_vld_q && (rw_q != RW_WORD || rd_hi_q)) cl_vld_q <= 1'b0;
          end
        end
      end
    end
  end

  assign src       = cl_vld_q ? cl_q : cnt_i;
  assign sel_hi    = (rw_q == RW_HI) || ((rw_q == RW_WORD) && rd_hi_q);
  assign rd_byte_o = st_vld_q ? st_q : (sel_hi ? src[15:8] : src[7:0]);
  assign mode_o    = mode_q;
  assign bcd_o     = bcd_q;
  assign st_vld_o  = st_vld_q;
  assign cl_vld_o  = cl_vld_q;
  assign cl_val_o  = cl_q;
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if import tmr_pkg::*; #(
  parameter int unsigned NCH = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [1:0]         addr_i,
  input  logic [7:0]         data_i,
  output logic [7:0]         data_o,
  input  logic [NCH*16-1:0]  cnt_i,
  input  logic [NCH-1:0]     out_i,
  input  logic [NCH-1:0]     null_i,
  output logic [NCH*3-1:0]   mode_o,
  output logic [NCH-1:0]     bcd_o,
  output logic [NCH-1:0]     ctrl_wr_o,
  output logic [NCH-1:0]     load_o,
  output logic [NCH*16-1:0]  load_val_o
);
  localparam int unsigned CW = CNT_W;

  logic             rd_ev, wr_ev;
  logic [NCH-1:0]   ch_rd, ch_wr, cw, lat, rb_cnt, rb_st, st_vld, cl_vld;
  logic [NCH*CW-1:0] cl_val;
  logic [7:0]       rd_byte [NCH];
  logic [7:0]       data_q;

  tmr_bus_strobe u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .rd_ni   (rd_ni),
    .wr_ni   (wr_ni),
    .rd_ev_o (rd_ev),
    .wr_ev_o (wr_ev)
  );

  tmr_cmd_decode #(.NCH(NCH)) u_dec (
    .rd_ev_i  (rd_ev),
    .wr_ev_i  (wr_ev),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .ch_rd_o  (ch_rd),
    .ch_wr_o  (ch_wr),
    .cw_o     (cw),
    .lat_o    (lat),
    .rb_cnt_o (rb_cnt),
    .rb_st_o  (rb_st)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_chan_port u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (ch_wr[c]),
      .rd_i       (ch_rd[c]),
      .cw_i       (cw[c]),
      .lat_i      (lat[c]),
      .rb_cnt_i   (rb_cnt[c]),
      .rb_st_i    (rb_st[c]),
      .data_i     (data_i),
      .cnt_i      (cnt_i[c*CW +: CW]),
      .out_i      (out_i[c]),
      .null_i     (null_i[c]),
      .rd_byte_o  (rd_byte[c]),
      .mode_o     (mode_o[c*3 +: 3]),
      .bcd_o      (bcd_o[c]),
      .ctrl_wr_o  (ctrl_wr_o[c]),
      .load_o     (load_o[c]),
      .load_val_o (load_val_o[c*CW +: CW]),
      .st_vld_o   (st_vld[c]),
      .cl_vld_o   (cl_vld[c]),
      .cl_val_o   (cl_val[c*CW +: CW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (rd_ev) begin
      data_q <= 8'h00;
      for (int c = 0; c < NCH; c++) begin
        if (addr_i == 2'(c)) data_q <= rd_byte[c];
      end
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/tmr_bus_if_chk.sv
module tmr_bus_if_chk #(
  parameter int unsigned NCH = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [1:0]        addr_i,
  input logic [7:0]        data_o,
  input logic [NCH-1:0]    load_o,
  input logic [NCH-1:0]    ctrl_wr_o,
  input logic [NCH-1:0]    st_vld,
  input logic [NCH-1:0]    cl_vld,
  input logic [NCH*16-1:0] cl_val
);
  AST_LOAD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o)); // R3
  AST_CTRL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_wr_o)); // R4
  AST_NO_ACT_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (load_o == '0 && ctrl_wr_o == '0)); // R1
  AST_LOAD_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o != '0) |-> $past(!cs_ni && !wr_ni && rd_ni)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni || !wr_ni) |=> $stable(data_o)); // R12

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_LATCH_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cl_vld[c] |=> (!cl_vld[c] || $stable(cl_val[c*16 +: 16]))); // R6
    AST_STATUS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_ni && !rd_ni && wr_ni && addr_i == 2'(c) && st_vld[c] && cl_vld[c])
      |=> cl_vld[c]); // R10
  end
endmodule

bind tmr_bus_if tmr_bus_if_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .wr_ni     (wr_ni),
  .addr_i    (addr_i),
  .data_o    (data_o),
  .load_o    (load_o),
  .ctrl_wr_o (ctrl_wr_o),
  .st_vld    (st_vld),
  .cl_vld    (cl_vld),
  .cl_val    (cl_val)
);

// File: tb/tmr_bus_if_bench.sv
module tmr_bus_if_bench;
  localparam int NCH = 3;
  localparam logic [1:0] K_WR = 2'd0, K_WRL = 2'd1, K_RD = 2'd2, K_LIVE = 2'd3;

  typedef struct packed {
    logic [1:0]  k;
    logic [1:0]  a;
    logic [7:0]  d;
    logic [15:0] x;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{K_LIVE, 2'd0, 8'h00, 16'h1234},
    '{K_WR,   2'd3, 8'h10, 16'h0000}, // R4 ch0 low only
    '{K_WRL,  2'd0, 8'h47, 16'h0047}, // R3
    '{K_RD,   2'd0, 8'h34, 16'h0000}, // R5
    '{K_WR,   2'd3, 8'h22, 16'h0000}, // R4 ch0 high only
    '{K_WRL,  2'd0, 8'h9A, 16'h9A00}, // R3
    '{K_RD,   2'd0, 8'h12, 16'h0000}, // R5
    '{K_WR,   2'd3, 8'h34, 16'h0000}, // R4 ch0 two-byte
    '{K_WR,   2'd0, 8'h78, 16'h0000}, // R3 first byte, no load
    '{K_WRL,  2'd0, 8'h56, 16'h5678}, // R3
    '{K_RD,   2'd0, 8'h34, 16'h0000}, // R5 low
    '{K_LIVE, 2'd0, 8'h00, 16'hABCD},
    '{K_RD,   2'd0, 8'hAB, 16'h0000}, // R5 high
    '{K_WR,   2'd3, 8'h00, 16'h0000}, // R6 latch ch0
    '{K_LIVE, 2'd0, 8'h00, 16'h1111},
    '{K_WR,   2'd3, 8'h00, 16'h0000}, // R7 second latch ignored
    '{K_LIVE, 2'd0, 8'h00, 16'h2222},
    '{K_RD,   2'd0, 8'hCD, 16'h0000}, // R6
    '{K_RD,   2'd0, 8'hAB, 16'h0000}, // R7
    '{K_RD,   2'd0, 8'h22, 16'h0000}, // R6 live again
    '{K_RD,   2'd0, 8'h22, 16'h0000}, // R5
    '{K_RD,   2'd3, 8'h00, 16'h0000}  // R12
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] data_o;
  logic [15:0] live [NCH];
  logic [NCH-1:0] out_lvl = '0, null_cnt = '0;
  logic [NCH*3-1:0] mode_o;
  logic [NCH-1:0] bcd_o, ctrl_wr_o, load_o;
  logic [NCH*16-1:0] load_val_o;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [NCH-1:0] cap_load, cap_ctrl;
  logic [NCH*16-1:0] cap_val;
  logic [7:0] rb;

  always #4 clk = ~clk;

  tmr_bus_if #(.NCH(NCH)) u_tmr_bus_if (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .addr_i(addr), .data_i(din), .data_o(data_o),
    .cnt_i({live[2], live[1], live[0]}), .out_i(out_lvl), .null_i(null_cnt),
    .mode_o(mode_o), .bcd_o(bcd_o), .ctrl_wr_o(ctrl_wr_o),
    .load_o(load_o), .load_val_o(load_val_o)
  );

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      report();
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_ni = 0; wr_ni = 0; addr = a; din = d;
    @(negedge clk); cap_load = load_o; cap_ctrl = ctrl_wr_o; cap_val = load_val_o;
    cs_ni = 1; wr_ni = 1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] q);
    @(negedge clk); cs_ni = 0; rd_ni = 0; addr = a;
    @(negedge clk); q = data_o;
    cs_ni = 1; rd_ni = 1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] q;
    bus_rd(a, q);
    check(req, {8'h00, q}, {8'h00, exp});
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) live[c] = '0;
    repeat (3) @(negedge clk);
    check("R2 data_o", {8'h00, data_o}, 16'h0000);
    check("R2 mode", {7'd0, mode_o}, 16'h0000);
    rst_ni = 1;
    @(negedge clk);
    check("R2 load", {13'd0, load_o}, 16'h0000);
    bus_wr(2'd3, 8'hEE); // status of all channels
    for (int c = 0; c < NCH; c++) rd_chk("R2 R9 reset status", 2'(c), 8'h30);

    for (int i = 0; i < NV; i++) begin
      vec_t v = TBL[i];
      case (v.k)
        K_LIVE: live[v.a] = v.x;
        K_WR: begin
          bus_wr(v.a, v.d);
          check("R3 R4 no load", {13'd0, cap_load}, 16'h0000);
        end
        K_WRL: begin
          bus_wr(v.a, v.d);
          check("R3 load pulse", {13'd0, cap_load}, 16'(1 << v.a));
          check("R3 load value", cap_val[v.a*16 +: 16], v.x);
        end
        default: rd_chk("R5 R6 R7 R12 table read", v.a, v.d);
      endcase
    end

    // R10 status first, then frozen count
    bus_wr(2'd3, 8'h76);
    check("R4 ctrl pulse", {13'd0, cap_ctrl}, 16'h0002);
    check("R4 mode ch1", {13'd0, mode_o[5:3]}, 16'h0003);
    live[1] = 16'h0304; out_lvl[1] = 1; null_cnt[1] = 1;
    bus_wr(2'd3, 8'hC4);
    live[1] = 16'h9999; out_lvl[1] = 0; null_cnt[1] = 0;
    rd_chk("R10 R9 status first", 2'd1, 8'hF6);
    rd_chk("R10 latched low", 2'd1, 8'h04);
    rd_chk("R10 latched high", 2'd1, 8'h03);
    rd_chk("R10 live after", 2'd1, 8'h99);

    // R11 second status request ignored
    live[2] = 16'h5A6B;
    bus_wr(2'd3, 8'hE8);
    out_lvl[2] = 1;
    bus_wr(2'd3, 8'hE8);
    rd_chk("R11 first status kept", 2'd2, 8'h30);
    rd_chk("R11 then live low", 2'd2, 8'h6B);

    // R1 held strobe, deselect, both strobes low
    @(negedge clk); cs_ni = 0; wr_ni = 0; addr = 2'd0; din = 8'h11;
    repeat (3) begin
      @(negedge clk);
      check("R1 held strobe no load", {13'd0, load_o}, 16'h0000);
    end
    cs_ni = 1; wr_ni = 1;
    @(negedge clk); cs_ni = 0; wr_ni = 0; rd_ni = 0; din = 8'h99;
    @(negedge clk);
    check("R12 both strobes no load", {13'd0, load_o}, 16'h0000);
    cs_ni = 1; wr_ni = 1; rd_ni = 1;
    @(negedge clk); wr_ni = 0; addr = 2'd3; din = 8'h10;
    @(negedge clk);
    check("R1 deselected ctrl", {13'd0, ctrl_wr_o}, 16'h0000);
    wr_ni = 1;
    bus_wr(2'd0, 8'h22);
    check("R1 pointer advanced once", cap_val[15:0], 16'h2211);
    check("R1 load once", {13'd0, cap_load}, 16'h0001);

    // R4 control write drops pending latch
    bus_wr(2'd3, 8'h00);
    bus_wr(2'd3, 8'h35);
    check("R4 ctrl ch0", {13'd0, cap_ctrl}, 16'h0001);
    check("R4 bcd", {15'd0, bcd_o[0]}, 16'h0001);
    check("R4 mode ch0", {13'd0, mode_o[2:0]}, 16'h0002);
    live[0] = 16'h4455;
    rd_chk("R4 latch dropped", 2'd0, 8'h55);

    // R8 count-only read-back on channels 0 and 2
    bus_wr(2'd3, 8'h34);
    bus_wr(2'd3, 8'hB0);
    live[2] = 16'h6677;
    bus_wr(2'd3, 8'hDA);
    live[0] = 16'h0000; live[2] = 16'h0000;
    rd_chk("R8 ch0 low", 2'd0, 8'h55);
    rd_chk("R8 ch0 high", 2'd0, 8'h44);
    rd_chk("R8 ch2 low", 2'd2, 8'h77);
    rd_chk("R8 ch2 high", 2'd2, 8'h66);

    report();
  end
endmodule